// File: doc/BRIEF.md
# Chained Loadable Up-Counter with Bounded Sequence Generator

This block is built from a narrow synchronous up-counter slice. The slice has a synchronous clear, a parallel load, a count enable and a carry-out flag. The carry-out is high only while the enable is high and the slice holds all ones. It is therefore a combinational (Mealy) function of the enable and the state. This lets an upper slice take its enable straight from the carry-out of the slice below, so several narrow slices form one wide binary counter with no extra logic between them.

The top module holds two users of the slice. The first is a chain of slices that forms a wide counter with a shared clear, load and enable. The second is a bounded sequence generator. It has one slice with its enable tied high and its load value tied to a lower bound. It reloads whenever the count sits on the upper bound or outside the bounded window, so the output runs 5, 6, 7, 8, 9 and then repeats.

Each slice picks one operation per edge: CLEAR, LOAD, STEP or HOLD. The priority is clear, then load, then enable. The transitions are:
- CLEAR whenever the clear input is high.
- LOAD when clear is low and load is high.
- STEP when only the enable is high.
- HOLD when none of the three is high.

Top module: `cascade_counter_top`

## Requirements
- R1: With `rst` high at a rising edge, both `chain_q` and `seq_q` become zero after that edge.
- R2: With `rst` low and `chain_load` high at an edge, `chain_q` takes `chain_load_val` after that edge, whatever `chain_en` is.
- R3: When `rst` and `chain_load` are both high at an edge, the clear wins and `chain_q` becomes zero.
- R4: With `rst`, `chain_load` and `chain_en` all low at an edge, `chain_q` keeps its value.
- R5: With only `chain_en` high at an edge, `chain_q` advances by one, and it wraps from all ones (0xFFF at default width) to zero.
- R6: `chain_tc` is high exactly when `chain_en` is high and `chain_q` is all ones. It follows `chain_en` in the same cycle, with no register delay.
- R7: A carry passes between slices in the same edge. When the low slice is all ones and counting, the next slice up increments, so 0x00F steps to 0x010 and 0x0FF steps to 0x100.
- R8: While `seq_q` is inside the window 5 to 9 and `rst` is low, each edge advances it by one. From 9 it returns to 5.
- R9: When `seq_q` is outside the window 5 to 9 (for example 0 right after a clear), the next edge without `rst` sets it to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear for the chain and the sequence generator |
| chain_load | input | 1 | Parallel load request for the chained counter |
| chain_load_val | input | 12 | Value loaded into the chained counter |
| chain_en | input | 1 | Count enable for the chained counter |
| chain_q | output | 12 | Chained counter value |
| chain_tc | output | 1 | High when the chain is enabled and all ones |
| seq_q | output | 4 | Bounded sequence output |

## Verification
The bench builds the default configuration: three 4-bit slices form a 12-bit chain, and the generator window runs from 5 to 9. With a 4-bit slice, each slice's all-ones boundary is a few loads away. Loads of 0x00F, 0x0FF and 0xFFF put the carry between slices and the full wrap into direct reach. Random loads that lean toward all-ones nibbles keep the carry paths exercised. Because the window sits inside a 4-bit slice, the reload from the zero left by a clear can be seen after every random clear.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // Operation selected by a slice at the next edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } slice_op_e;

endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         en,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] ONE = W'(1);

    slice_op_e    op;
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;

    // Operation select: clear over load over step.
    always_comb begin
        if (clr) begin
            op = OP_CLEAR;
        end else if (ld) begin
            op = OP_LOAD;
        end else if (en) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

    // Next value for each operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: q_nxt = '0;
            OP_LOAD:  q_nxt = ld_val;
            OP_STEP:  q_nxt = q_r + ONE;
            OP_HOLD:  q_nxt = q_r;
            default:  q_nxt = q_r;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        q_r <= q_nxt;
    end

    // Outputs: carry-out depends on the live enable (Mealy).
    assign q  = q_r;
    assign tc = en & (&q_r);

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
    parameter int W = 4,
    parameter int N = 3
) (
    input  logic           clk,
    input  logic           clr,
    input  logic           ld,
    input  logic [W*N-1:0] ld_val,
    input  logic           en,
    output logic [W*N-1:0] q,
    output logic           tc
);

    // carry[i] enables slice i; carry[N] is the chain carry-out.
    logic [N:0] carry;

    assign carry[0] = en;

    for (genvar i = 0; i < N; i++) begin : g_slice
        cnt_slice #(
            .W(W)
        ) u_slice (
            .clk   (clk),
            .clr   (clr),
            .ld    (ld),
            .ld_val(ld_val[i*W +: W]),
            .en    (carry[i]),
            .q     (q[i*W +: W]),
            .tc    (carry[i+1])
        );
    end

    assign tc = carry[N];

endmodule

// File: rtl/cnt_seq.sv
module cnt_seq #(
    parameter int W  = 4,
    parameter int LO = 5,
    parameter int HI = 9
) (
    input  logic         clk,
    input  logic         clr,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    logic [W-1:0] q_s;
    logic         reload;
    logic         tc_unused;

    // Reload on the upper bound or on any value outside the window.
    assign reload = (q_s == HI_V) || (q_s < LO_V) || (q_s > HI_V);

    cnt_slice #(
        .W(W)
    ) u_slice (
        .clk   (clk),
        .clr   (clr),
        .ld    (reload),
        .ld_val(LO_V),
        .en    (1'b1),
        .q     (q_s),
        .tc    (tc_unused)
    );

    assign q = q_s;

endmodule

// File: rtl/cascade_counter_top.sv
module cascade_counter_top #(
    parameter int SLICE_W = 4,
    parameter int SLICES  = 3,
    parameter int SEQ_LO  = 5,
    parameter int SEQ_HI  = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       chain_load,
    input  logic [SLICE_W*SLICES-1:0]  chain_load_val,
    input  logic                       chain_en,
    output logic [SLICE_W*SLICES-1:0]  chain_q,
    output logic                       chain_tc,
    output logic [SLICE_W-1:0]         seq_q
);

    cnt_chain #(
        .W(SLICE_W),
        .N(SLICES)
    ) u_chain (
        .clk   (clk),
        .clr   (rst),
        .ld    (chain_load),
        .ld_val(chain_load_val),
        .en    (chain_en),
        .q     (chain_q),
        .tc    (chain_tc)
    );

    cnt_seq #(
        .W (SLICE_W),
        .LO(SEQ_LO),
        .HI(SEQ_HI)
    ) u_seq (
        .clk(clk),
        .clr(rst),
        .q  (seq_q)
    );

endmodule

// File: rtl/cascade_counter_checker.sv
module cascade_counter_checker #(
    parameter int SLICE_W = 4,
    parameter int SLICES  = 3,
    parameter int SEQ_LO  = 5,
    parameter int SEQ_HI  = 9
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      chain_load,
    input logic [SLICE_W*SLICES-1:0] chain_load_val,
    input logic                      chain_en,
    input logic [SLICE_W*SLICES-1:0] chain_q,
    input logic                      chain_tc,
    input logic [SLICE_W-1:0]        seq_q
);

    localparam int CW = SLICE_W * SLICES;
    localparam logic [CW-1:0]      C_ONE = CW'(1);
    localparam logic [SLICE_W-1:0] S_ONE = SLICE_W'(1);
    localparam logic [SLICE_W-1:0] S_LO  = SLICE_W'(SEQ_LO);
    localparam logic [SLICE_W-1:0] S_HI  = SLICE_W'(SEQ_HI);

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        rst |=> (chain_q == '0) && (seq_q == '0)); // R1

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        chain_load |=> chain_q == $past(chain_load_val)); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!chain_load && !chain_en) |=> $stable(chain_q)); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!chain_load && chain_en) |=> chain_q == $past(chain_q) + C_ONE); // R5

    AST_TC_MEALY: assert property (@(posedge clk) disable iff (rst)
        chain_tc == (chain_en && (&chain_q))); // R6

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        ((seq_q >= S_LO) && (seq_q <= S_HI)) |=>
        seq_q == (($past(seq_q) == S_HI) ? S_LO : $past(seq_q) + S_ONE)); // R8

    AST_SEQ_RECOVER: assert property (@(posedge clk) disable iff (rst)
        ((seq_q < S_LO) || (seq_q > S_HI)) |=> seq_q == S_LO); // R9

endmodule

bind cascade_counter_top cascade_counter_checker #(
    .SLICE_W(SLICE_W),
    .SLICES (SLICES),
    .SEQ_LO (SEQ_LO),
    .SEQ_HI (SEQ_HI)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .chain_load    (chain_load),
    .chain_load_val(chain_load_val),
    .chain_en      (chain_en),
    .chain_q       (chain_q),
    .chain_tc      (chain_tc),
    .seq_q         (seq_q)
);

// File: tb/cascade_counter_top_bench.sv
`timescale 1ns/1ps
module cascade_counter_top_bench;

    localparam int SW = 4;
    localparam int NS = 3;
    localparam int CW = SW * NS;
    localparam logic [CW-1:0] ALL1 = '1;

    logic          clk = 1'b0;
    logic          rst;
    logic          chain_load;
    logic [CW-1:0] chain_load_val;
    logic          chain_en;
    logic [CW-1:0] chain_q;
    logic          chain_tc;
    logic [SW-1:0] seq_q;

    int errors = 0;
    int checks = 0;

    logic [CW-1:0] exp_c;
    logic [SW-1:0] exp_s;

    always #5 clk = ~clk;

    cascade_counter_top u_cascade_counter_top (
        .clk           (clk),
        .rst           (rst),
        .chain_load    (chain_load),
        .chain_load_val(chain_load_val),
        .chain_en      (chain_en),
        .chain_q       (chain_q),
        .chain_tc      (chain_tc),
        .seq_q         (seq_q)
    );

    function automatic logic [CW-1:0] chain_model(logic [CW-1:0] q, logic r,
                                                  logic l, logic [CW-1:0] v, logic e);
        if (r)      return '0;
        else if (l) return v;
        else if (e) return q + CW'(1);
        else        return q;
    endfunction

    function automatic logic [SW-1:0] seq_model(logic [SW-1:0] q, logic r);
        if (r)                          return '0;
        else if (q == 4'd9 || q < 4'd5 || q > 4'd9) return 4'd5;
        else                            return q + 4'd1;
    endfunction

    task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check the Mealy flag, then the registers.
    task automatic cycle(logic r, logic l, logic [CW-1:0] v, logic e);
        string tag;
        string stag;
        @(negedge clk);
        rst = r; chain_load = l; chain_load_val = v; chain_en = e;
        #1;
        check("R6 tc", {{(CW-1){1'b0}}, chain_tc},
              {{(CW-1){1'b0}}, (e && exp_c == ALL1)});
        if (r && l)                       tag = "R3 clear over load";
        else if (r)                       tag = "R1 clear";
        else if (l)                       tag = "R2 load";
        else if (e && exp_c[SW-1:0] == '1) tag = "R7 carry/R5 wrap";
        else if (e)                       tag = "R5 step";
        else                              tag = "R4 hold";
        if (r)                                   stag = "R1 seq clear";
        else if (exp_s < 4'd5 || exp_s > 4'd9)   stag = "R9 seq recover";
        else                                     stag = "R8 seq advance";
        exp_c = chain_model(exp_c, r, l, v, e);
        exp_s = seq_model(exp_s, r);
        @(posedge clk);
        #1;
        check(tag, chain_q, exp_c);
        check(stag, {{(CW-SW){1'b0}}, seq_q}, {{(CW-SW){1'b0}}, exp_s});
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; chain_load = 1'b0; chain_load_val = '0; chain_en = 1'b0;
        exp_c = '0; exp_s = '0;
        // R1 reset state
        cycle(1'b1, 1'b0, '0, 1'b0);
        cycle(1'b1, 1'b0, '0, 1'b1);
        // R9 first edge after clear goes to 5, then R8 sequence
        for (int i = 0; i < 12; i++) cycle(1'b0, 1'b0, '0, 1'b0);
        // R2 load all ones with enable high, R6 tc, R5 full wrap
        cycle(1'b0, 1'b1, ALL1, 1'b1);
        cycle(1'b0, 1'b0, '0, 1'b1);
        // R7 carry into second and third slices
        cycle(1'b0, 1'b1, 12'h00F, 1'b0);
        cycle(1'b0, 1'b0, '0, 1'b1);
        cycle(1'b0, 1'b1, 12'h0FF, 1'b0);
        cycle(1'b0, 1'b0, '0, 1'b1);
        // R4 hold with all ones, tc must stay low with enable low
        cycle(1'b0, 1'b1, ALL1, 1'b0);
        cycle(1'b0, 1'b0, '0, 1'b0);
        cycle(1'b0, 1'b0, '0, 1'b0);
        // R3 clear beats load
        cycle(1'b1, 1'b1, 12'hABC, 1'b1);
        // Random mix, loads biased toward all-ones nibbles
        for (int i = 0; i < 3000; i++) begin
            logic          r;
            logic          l;
            logic          e;
            logic [CW-1:0] v;
            r = ($urandom % 40) == 0;
            l = ($urandom % 8) == 0;
            e = ($urandom % 4) != 0;
            v = CW'($urandom);
            if ($urandom % 2) v[SW-1:0] = '1;
            if ($urandom % 3 == 0) v[2*SW-1:SW] = '1;
            cycle(r, l, v, e);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule